// File: doc/BRIEF.md
# Four-Plane Pixel Write Engine

This block forms the write path of a graphics controller whose display memory is split into four byte-wide planes. Each host write supplies one byte. The block combines that byte with a set of control fields and with the 32-bit latch contents, which hold one byte per plane from an earlier memory read. From these it computes the four plane bytes to store and a write strobe for each plane. One of four write modes is chosen. The modes differ in where the new data comes from: the rotated host byte, a per-plane colour expanded to a full byte, the low host bits spread across their planes, or the latch itself. They also differ in whether a logic operation with the latch is applied, and in how the per-bit mask is formed.

The control fields are held in registers inside the block and are loaded through an index/data pair: one write selects an index, and a later data write updates the field at that index. A host write is presented for one cycle. The resulting plane bytes and strobes appear on registered outputs on the next cycle. Plane p sits at bits [8p+7:8p] of every 32-bit bus.

Top module: `plane_write_engine`

## Requirements
- R1: After reset every control field is zero (write mode 0, rotate 0, pass-through, set/reset and its enable 0, mask 0x00), so a host write returns the latch unchanged; the strobes are 0 while no write is presented.
- R2: In write modes 0 and 3 the host byte is rotated right by the 3-bit rotate count: each step moves bit 0 to bit 7 and every other bit down one place.
- R3: In write mode 0, each plane whose enable bit (bit p of the enable field) is 1 takes its set/reset bit p repeated eight times, in place of the rotated host byte.
- R4: The logic operation is applied per bit against the latch in write modes 0 and 2: code 0 passes, 1 ANDs, 2 ORs, 3 XORs.
- R5: In modes 0 and 2, a mask bit of 1 takes the bit from the pipeline and a mask bit of 0 takes the same bit of the latch, in all four planes.
- R6: In write mode 1 the output equals the latch; the host byte, mask and logic operation have no effect.
- R7: In write mode 2, host bit p (p = 0..3) is repeated across all eight bits of plane p, then R4 and R5 apply; the rotate count has no effect.
- R8: In write mode 3, each plane takes its set/reset bit repeated eight times, whatever the enable field holds. The effective mask is the rotated host byte ANDed with the mask field. The logic operation is not applied.
- R9: One cycle after a host write, the strobes equal the plane enables of that write; in any cycle without a write they are 0 and the plane data holds its value.
- R10: Field map: index 0x00 bits 3:0 set/reset; 0x01 bits 3:0 set/reset enable; 0x03 bits 2:0 rotate count and bits 4:3 logic operation; 0x05 bits 1:0 write mode; 0x08 bits 7:0 bit mask. A data write updates the field selected by the last index written, and the new value applies to a host write in the next cycle.
- R11: Data writes while the index holds any other 8-bit value (0x02 or 0x18, for example) leave every field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_idx_we | input | 1 | Load cfg_wdata into the index register |
| cfg_dat_we | input | 1 | Write cfg_wdata into the field selected by the index |
| cfg_wdata | input | 8 | Index or field value |
| host_wr | input | 1 | Host write presented this cycle |
| host_byte | input | 8 | Host write data |
| latch_in | input | 32 | Latch contents, one byte per plane |
| plane_en | input | 4 | Plane write enables |
| plane_data | output | 32 | Bytes to store, one per plane |
| plane_strobe | output | 4 | Per-plane write strobes |

## Verification
The assertions assume that the latch and the plane enables are valid in every cycle where host_wr is high. They also assume that index and data writes to the control fields can arrive at any time, in the same cycle as a host write or not. The stimulus never changes the configuration and issues a host write in the same cycle. It programs all five fields, holds host_wr low, and only then presents a single-cycle host write. It then leaves an idle cycle, which exercises the hold and strobe-clear behaviour as well.

// File: rtl/pwe_pkg.sv
// Package: shared sizes, field encodings and the byte rotation helper for
// the four-plane write engine. Assumes power-of-two lane width.
package pwe_pkg;
    localparam int PLANES  = 4;
    localparam int LANE_W  = 8;
    localparam int BUS_W   = PLANES * LANE_W;
    localparam int ROT_W   = $clog2(LANE_W);
    localparam int IDX_W   = 8;

    // Field indices (decoded by the configuration bank)
    localparam logic [IDX_W-1:0] IDX_SETRST = 8'h00;
    localparam logic [IDX_W-1:0] IDX_SR_EN  = 8'h01;
    localparam logic [IDX_W-1:0] IDX_ROTOP  = 8'h03;
    localparam logic [IDX_W-1:0] IDX_MODE   = 8'h05;
    localparam logic [IDX_W-1:0] IDX_MASK   = 8'h08;

    typedef enum logic [1:0] {
        WM_HOST   = 2'd0,
        WM_LATCH  = 2'd1,
        WM_SPREAD = 2'd2,
        WM_COLOR  = 2'd3
    } wmode_t;

    typedef enum logic [1:0] {
        OP_PASS = 2'd0,
        OP_AND  = 2'd1,
        OP_OR   = 2'd2,
        OP_XOR  = 2'd3
    } lop_t;

    // Rotate a lane right by n positions, wrapping low bits to the top.
    function automatic logic [LANE_W-1:0] rotr(input logic [LANE_W-1:0] d,
                                               input logic [ROT_W-1:0]  n);
        logic [2*LANE_W-1:0] w;
        w = {d, d} >> n;
        return w[LANE_W-1:0];
    endfunction
endpackage

// File: rtl/pwe_cfg_bank.sv
// Configuration bank: an index register plus the five control fields.
// Assumes index and data writes are single-cycle strobes; unknown indices
// are dropped silently. All state clears on synchronous active-low reset.
module pwe_cfg_bank
    import pwe_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  idx_we,
    input  logic                  dat_we,
    input  logic [IDX_W-1:0]      wdata,
    output logic [IDX_W-1:0]      idx_q,
    output logic [PLANES-1:0]     setrst,
    output logic [PLANES-1:0]     sr_en,
    output logic [ROT_W-1:0]      rot_cnt,
    output lop_t                  lop,
    output wmode_t                wmode,
    output logic [LANE_W-1:0]     bit_mask
);
    // Index register: remembers which field the next data write targets.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_we) idx_q <= wdata;
    end

    // Field registers: update the selected field, ignore unmapped indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setrst   <= '0;
            sr_en    <= '0;
            rot_cnt  <= '0;
            lop      <= OP_PASS;
            wmode    <= WM_HOST;
            bit_mask <= '0;
        end else if (dat_we) begin
            case (idx_q)
                IDX_SETRST: setrst   <= wdata[PLANES-1:0];
                IDX_SR_EN:  sr_en    <= wdata[PLANES-1:0];
                IDX_ROTOP: begin
                    rot_cnt <= wdata[ROT_W-1:0];
                    lop     <= lop_t'(wdata[ROT_W+1:ROT_W]);
                end
                IDX_MODE:   wmode    <= wmode_t'(wdata[1:0]);
                IDX_MASK:   bit_mask <= wdata[LANE_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pwe_source.sv
// Source stage: rotates the host byte, chooses per-plane source data for
// the current write mode and forms the effective bit mask.
// Purely combinational; mode 1 source is unused downstream.
module pwe_source
    import pwe_pkg::*;
(
    input  logic [LANE_W-1:0]  host_byte,
    input  wmode_t             wmode,
    input  logic [ROT_W-1:0]   rot_cnt,
    input  logic [PLANES-1:0]  setrst,
    input  logic [PLANES-1:0]  sr_en,
    input  logic [LANE_W-1:0]  bit_mask,
    output logic [BUS_W-1:0]   src_data,
    output logic [LANE_W-1:0]  eff_mask
);
    logic [LANE_W-1:0] rot_byte;

    // Rotation shared by modes 0 and 3.
    always_comb rot_byte = rotr(host_byte, rot_cnt);

    // Effective mask: host-modulated in mode 3, the field itself otherwise.
    always_comb eff_mask = (wmode == WM_COLOR) ? (rot_byte & bit_mask) : bit_mask;

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        // Per-plane data selection for the active write mode.
        always_comb begin
            unique case (wmode)
                WM_HOST:   src_data[p*LANE_W +: LANE_W] =
                               sr_en[p] ? {LANE_W{setrst[p]}} : rot_byte;
                WM_SPREAD: src_data[p*LANE_W +: LANE_W] = {LANE_W{host_byte[p]}};
                WM_COLOR:  src_data[p*LANE_W +: LANE_W] = {LANE_W{setrst[p]}};
                default:   src_data[p*LANE_W +: LANE_W] = rot_byte;
            endcase
        end
    end
endmodule

// File: rtl/pwe_lane.sv
// One plane lane: logic operation against the latch byte, mask merge and
// the latch-copy override. Combinational; one instance per plane.
module pwe_lane
    import pwe_pkg::*;
(
    input  wmode_t             wmode,
    input  lop_t               lop,
    input  logic [LANE_W-1:0]  src,
    input  logic [LANE_W-1:0]  latch,
    input  logic [LANE_W-1:0]  eff_mask,
    output logic [LANE_W-1:0]  result
);
    logic [LANE_W-1:0] alu_out;
    logic [LANE_W-1:0] merged;

    // Logic unit: only modes 0 and 2 pass through it.
    always_comb begin
        if (wmode == WM_HOST || wmode == WM_SPREAD) begin
            unique case (lop)
                OP_AND:  alu_out = src & latch;
                OP_OR:   alu_out = src | latch;
                OP_XOR:  alu_out = src ^ latch;
                default: alu_out = src;
            endcase
        end else begin
            alu_out = src;
        end
    end

    // Mask merge: 1 keeps pipeline bit, 0 keeps latch bit.
    always_comb merged = (alu_out & eff_mask) | (latch & ~eff_mask);

    // Mode 1 writes the latch untouched.
    always_comb result = (wmode == WM_LATCH) ? latch : merged;
endmodule

// File: rtl/plane_write_engine.sv
// Top of the four-plane write engine. Holds the control fields, computes
// plane data combinationally and registers data and strobes, one cycle
// after host_wr. Assumes latch_in and plane_en are valid with host_wr.
module plane_write_engine
    import pwe_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_idx_we,
    input  logic                  cfg_dat_we,
    input  logic [IDX_W-1:0]      cfg_wdata,
    input  logic                  host_wr,
    input  logic [LANE_W-1:0]     host_byte,
    input  logic [BUS_W-1:0]      latch_in,
    input  logic [PLANES-1:0]     plane_en,
    output logic [BUS_W-1:0]      plane_data,
    output logic [PLANES-1:0]     plane_strobe
);
    logic [IDX_W-1:0]  idx_q;
    logic [PLANES-1:0] setrst;
    logic [PLANES-1:0] sr_en;
    logic [ROT_W-1:0]  rot_cnt;
    lop_t              lop;
    wmode_t            wmode;
    logic [LANE_W-1:0] bit_mask;
    logic [BUS_W-1:0]  src_data;
    logic [LANE_W-1:0] eff_mask;
    logic [BUS_W-1:0]  next_data;

    pwe_cfg_bank u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_we   (cfg_idx_we),
        .dat_we   (cfg_dat_we),
        .wdata    (cfg_wdata),
        .idx_q    (idx_q),
        .setrst   (setrst),
        .sr_en    (sr_en),
        .rot_cnt  (rot_cnt),
        .lop      (lop),
        .wmode    (wmode),
        .bit_mask (bit_mask)
    );

    pwe_source u_src (
        .host_byte (host_byte),
        .wmode     (wmode),
        .rot_cnt   (rot_cnt),
        .setrst    (setrst),
        .sr_en     (sr_en),
        .bit_mask  (bit_mask),
        .src_data  (src_data),
        .eff_mask  (eff_mask)
    );

    for (genvar p = 0; p < PLANES; p++) begin : g_lane
        pwe_lane u_lane (
            .wmode    (wmode),
            .lop      (lop),
            .src      (src_data[p*LANE_W +: LANE_W]),
            .latch    (latch_in[p*LANE_W +: LANE_W]),
            .eff_mask (eff_mask),
            .result   (next_data[p*LANE_W +: LANE_W])
        );
    end

    // Output data register: captures a result only on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)       plane_data <= '0;
        else if (host_wr) plane_data <= next_data;
    end

    // Strobe register: plane enables for one cycle after a host write.
    always_ff @(posedge clk) begin
        if (!rst_n) plane_strobe <= '0;
        else        plane_strobe <= host_wr ? plane_en : '0;
    end
endmodule

// File: rtl/pwe_checker.sv
// Checker for the write engine; attached to every instance by bind below.
// Assumes the bound signals are those of plane_write_engine.
module pwe_checker
    import pwe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_dat_we,
    input logic [IDX_W-1:0]  idx_q,
    input logic [PLANES-1:0] setrst,
    input logic [PLANES-1:0] sr_en,
    input logic [ROT_W-1:0]  rot_cnt,
    input lop_t              lop,
    input wmode_t            wmode,
    input logic [LANE_W-1:0] bit_mask,
    input logic              host_wr,
    input logic [BUS_W-1:0]  latch_in,
    input logic [PLANES-1:0] plane_en,
    input logic [BUS_W-1:0]  plane_data,
    input logic [PLANES-1:0] plane_strobe
);
    logic mapped_idx;
    always_comb mapped_idx = (idx_q == IDX_SETRST) || (idx_q == IDX_SR_EN) ||
                             (idx_q == IDX_ROTOP)  || (idx_q == IDX_MODE)  ||
                             (idx_q == IDX_MASK);

    AST_MODE1_COPIES_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && wmode == WM_LATCH) |=> plane_data == $past(latch_in)); // R6

    AST_ZERO_MASK_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && bit_mask == '0) |=> plane_data == $past(latch_in)); // R5

    AST_STROBE_FOLLOWS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> plane_strobe == $past(plane_en)); // R9

    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> (plane_strobe == '0 && $stable(plane_data))); // R9

    AST_UNUSED_INDEX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dat_we && !mapped_idx) |=> ($stable(setrst) && $stable(sr_en) &&
        $stable(rot_cnt) && $stable(lop) && $stable(wmode) && $stable(bit_mask))); // R11
endmodule

bind plane_write_engine pwe_checker u_pwe_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_dat_we   (cfg_dat_we),
    .idx_q        (idx_q),
    .setrst       (setrst),
    .sr_en        (sr_en),
    .rot_cnt      (rot_cnt),
    .lop          (lop),
    .wmode        (wmode),
    .bit_mask     (bit_mask),
    .host_wr      (host_wr),
    .latch_in     (latch_in),
    .plane_en     (plane_en),
    .plane_data   (plane_data),
    .plane_strobe (plane_strobe)
);

// File: tb/plane_write_engine_bench.sv
// Bench: vector table walked by one loop, then directed reset and corner tests.
module plane_write_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_idx_we, cfg_dat_we;
    logic [7:0]  cfg_wdata;
    logic        host_wr;
    logic [7:0]  host_byte;
    logic [31:0] latch_in;
    logic [3:0]  plane_en;
    logic [31:0] plane_data;
    logic [3:0]  plane_strobe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    plane_write_engine u_plane_write_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_idx_we   (cfg_idx_we),
        .cfg_dat_we   (cfg_dat_we),
        .cfg_wdata    (cfg_wdata),
        .host_wr      (host_wr),
        .host_byte    (host_byte),
        .latch_in     (latch_in),
        .plane_en     (plane_en),
        .plane_data   (plane_data),
        .plane_strobe (plane_strobe)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [3:0]  sr;
        logic [3:0]  esr;
        logic [2:0]  rot;
        logic [1:0]  op;
        logic [1:0]  mode;
        logic [7:0]  mask;
        logic [7:0]  host;
        logic [31:0] latch;
        logic [3:0]  pen;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t TBL [NVEC] = '{
        '{4'd2,  4'h0, 4'h0, 3'd3, 2'd0, 2'd0, 8'hFF, 8'h81, 32'h00000000, 4'hF, 32'h30303030}, // R2
        '{4'd3,  4'h5, 4'h3, 3'd0, 2'd0, 2'd0, 8'hFF, 8'hA5, 32'h00000000, 4'hF, 32'hA5A500FF}, // R3
        '{4'd4,  4'h0, 4'h0, 3'd0, 2'd1, 2'd0, 8'hFF, 8'hF0, 32'h3C3C3C3C, 4'h5, 32'h30303030}, // R4 AND
        '{4'd4,  4'h0, 4'h0, 3'd0, 2'd2, 2'd0, 8'hFF, 8'h0F, 32'h12345678, 4'hF, 32'h1F3F5F7F}, // R4 OR
        '{4'd4,  4'h0, 4'h0, 3'd0, 2'd3, 2'd0, 8'hFF, 8'hFF, 32'h12345678, 4'hF, 32'hEDCBA987}, // R4 XOR
        '{4'd5,  4'h0, 4'h0, 3'd0, 2'd0, 2'd0, 8'h0F, 8'hAA, 32'h55555555, 4'hF, 32'h5A5A5A5A}, // R5
        '{4'd6,  4'h0, 4'h0, 3'd0, 2'd3, 2'd1, 8'h00, 8'hFF, 32'hDEADBEEF, 4'hA, 32'hDEADBEEF}, // R6
        '{4'd7,  4'h0, 4'h0, 3'd5, 2'd0, 2'd2, 8'hFF, 8'h06, 32'h00000000, 4'hF, 32'h00FFFF00}, // R7
        '{4'd7,  4'h0, 4'h0, 3'd0, 2'd3, 2'd2, 8'hFF, 8'h09, 32'h0F0F0F0F, 4'hF, 32'hF00F0FF0}, // R7 with XOR
        '{4'd8,  4'h3, 4'h0, 3'd1, 2'd3, 2'd3, 8'hF0, 8'h0F, 32'h11111111, 4'hF, 32'h11119191}, // R8
        '{4'd10, 4'h8, 4'hC, 3'd4, 2'd0, 2'd0, 8'h3C, 8'h1E, 32'hFFFFFFFF, 4'h3, 32'hFFC3E3E3}  // R10 all fields
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] idx, input logic [7:0] val);
        @(negedge clk); cfg_idx_we = 1'b1; cfg_wdata = idx;
        @(negedge clk); cfg_idx_we = 1'b0; cfg_dat_we = 1'b1; cfg_wdata = val;
        @(negedge clk); cfg_dat_we = 1'b0;
    endtask

    // Present one host write; returns after the registered outputs update.
    task automatic host_write(input logic [7:0] hb, input logic [31:0] lt, input logic [3:0] pe);
        @(negedge clk); host_wr = 1'b1; host_byte = hb; latch_in = lt; plane_en = pe;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected<100000", cycles);
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; cfg_idx_we = 0; cfg_dat_we = 0; cfg_wdata = 0;
        host_wr = 0; host_byte = 0; latch_in = 0; plane_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of strobes and data
        check("R1 strobe", {28'd0, plane_strobe}, 32'h0);
        check("R1 data", plane_data, 32'h0);
        // R1: cleared fields -> mask 0 -> latch returned
        host_write(8'hFF, 32'h12345678, 4'hF);
        check("R1 latch kept", plane_data, 32'h12345678);
        check("R9 strobe", {28'd0, plane_strobe}, 32'hF);
        @(negedge clk);
        check("R9 idle strobe", {28'd0, plane_strobe}, 32'h0);
        check("R9 idle hold", plane_data, 32'h12345678);

        for (int i = 0; i < NVEC; i++) begin
            cfg_write(8'h00, {4'h0, TBL[i].sr});
            cfg_write(8'h01, {4'h0, TBL[i].esr});
            cfg_write(8'h03, {3'b000, TBL[i].op, TBL[i].rot});
            cfg_write(8'h05, {6'd0, TBL[i].mode});
            cfg_write(8'h08, TBL[i].mask);
            host_write(TBL[i].host, TBL[i].latch, TBL[i].pen);
            check($sformatf("R%0d vec%0d data", TBL[i].req, i), plane_data, TBL[i].exp);
            check($sformatf("R9 vec%0d strobe", i), {28'd0, plane_strobe}, {28'd0, TBL[i].pen});
        end

        // R11: unmapped indices must not alter the mask or mode
        cfg_write(8'h00, 8'h00); cfg_write(8'h01, 8'h00);
        cfg_write(8'h03, 8'h00); cfg_write(8'h05, 8'h00);
        cfg_write(8'h08, 8'hFF);
        cfg_write(8'h18, 8'h00);
        cfg_write(8'h02, 8'h0F);
        cfg_write(8'h15, 8'h01);
        host_write(8'hAA, 32'h00000000, 4'hF);
        check("R11 unmapped ignored", plane_data, 32'hAAAAAAAA);

        // R6: host byte changes do not matter in mode 1
        cfg_write(8'h05, 8'h01);
        host_write(8'h00, 32'hCAFEF00D, 4'h1);
        check("R6 host ignored", plane_data, 32'hCAFEF00D);
        check("R9 single plane", {28'd0, plane_strobe}, 32'h1);

        // R10: new mask is used by a write in the very next cycle
        cfg_write(8'h05, 8'h00);
        @(negedge clk); cfg_idx_we = 1'b1; cfg_wdata = 8'h08;
        @(negedge clk); cfg_idx_we = 1'b0; cfg_dat_we = 1'b1; cfg_wdata = 8'hF0;
        @(negedge clk); cfg_dat_we = 1'b0;
        host_wr = 1'b1; host_byte = 8'h00; latch_in = 32'hFFFFFFFF; plane_en = 4'hF;
        @(negedge clk); host_wr = 1'b0;
        check("R10 next-cycle mask", plane_data, 32'h0F0F0F0F);

        // R2: full wrap with rotate 7 in mode 3 (mask from rotated host)
        cfg_write(8'h00, 8'h0F); cfg_write(8'h01, 8'h00);
        cfg_write(8'h03, 8'h07); cfg_write(8'h05, 8'h03);
        cfg_write(8'h08, 8'hFF);
        host_write(8'h01, 32'h00000000, 4'hF);
        check("R2 R8 rotate 7", plane_data, 32'h02020202);

        // R1: reset mid-run clears the fields again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        host_write(8'h55, 32'hA5A5A5A5, 4'hF);
        check("R1 after reset", plane_data, 32'hA5A5A5A5);

        finish_run();
    end
endmodule